// File: doc/BRIEF.md
# Configuration Word Register and Power-Mode Controller

This block holds the converter's 8-bit configuration word. Software-facing logic writes the word over the upper bits of the channel A data bus. An active-low write strobe captures it, and that strobe runs in its own timing domain, apart from the sample clock. The captured word moves into the sample-clock domain through a toggle handshake with a synchronizer. The block then decodes it into four outputs, which all change on the same clock edge: a power mode (normal, standby or power-down), an interleave enable, an internal-reference enable and a 4-bit gain-trim code.

A four-state machine tracks the converter's readiness and drives an output-valid flag. The states are RUN (valid), STBY (standby), PDN (power-down) and WAKE (counting down a wake-up delay). The transitions are:

- RUN goes to STBY or PDN when a standby or power-down word arrives.
- STBY goes to WAKE when a normal word arrives, loading the standby delay. It goes to PDN when a power-down word arrives.
- PDN goes to WAKE when a normal word arrives, loading the power-down delay. It goes to STBY when a standby word arrives.
- WAKE goes to RUN when its count expires. It goes to STBY or PDN when a standby or power-down word arrives, which abandons the count.

The delays are given in nanoseconds and converted to sample-clock cycles from a clock-rate parameter. Conversion rounds up.

Top module: `dac_cfg_ctrl`

## Requirements
- R1: After reset, the outputs are: pwr_mode = 00 (normal), ilv_en = 0, iref_en = 1, gain_trim = 4'b1000 (0 dB) and out_valid = 1.
- R2: On the rising edge of wr_n, the block captures data_a[9:2] as the configuration word. The bit fields are:
  - bit 9: power-down
  - bit 8: converter enable
  - bit 7: interleave enable (drives ilv_en)
  - bit 6: reference disable (iref_en = NOT bit 6)
  - bits 5:2: gain_trim
- R3: When data_a[9] = 1, pwr_mode becomes 10 (power-down), whatever the other bits hold. pwr_mode never takes the value 11.
- R4: When data_a[9] = 0, pwr_mode becomes 01 (standby) if data_a[8] = 0, and 00 (normal) if data_a[8] = 1.
- R5: data_a[1:0] has no effect on any output.
- R6: All decoded outputs change together, within 4 sample-clock cycles after the strobe's rising edge. No output changes unless a write has been handed over.
- R7: out_valid is 0 whenever pwr_mode is not 00.
- R8: When the mode goes from standby to normal, out_valid rises exactly STBY_CYC = ceil(CLK_MHZ·STBY_WAKE_NS/1000) cycles after pwr_mode turns 00.
- R9: When the mode goes from power-down to normal, out_valid rises exactly PD_CYC = ceil(CLK_MHZ·PD_WAKE_NS/1000) cycles after pwr_mode turns 00.
- R10: A normal-mode write made while out_valid = 1 keeps out_valid at 1.
- R11: A standby or power-down write made during a wake-up count abandons that count. out_valid stays 0, and the next normal write starts a fresh count.
- R12: data_a is sampled only at the rising edge of wr_n. Bus activity at any other time leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe; the word is captured on its rising edge |
| data_a | input | BUS_W (10) | Channel A data bus carrying the word in bits 9:2 |
| pwr_mode | output | 2 | 00 normal, 01 standby, 10 power-down |
| ilv_en | output | 1 | Interleaved input mode enable |
| iref_en | output | 1 | Internal reference enable |
| gain_trim | output | 4 | Gain-trim code |
| out_valid | output | 1 | Converter output valid after wake-up |

## Verification
The bench writes random 10-bit words, with random don't-care bits and garbage driven on the bus after each strobe, and compares every decoded field against a bench model. Mixing power-down with random enable bits separates the priority of bit 9 from a decode of bit 8 alone. Directed sequences cover each wake path:
- standby to normal and power-down to normal, where counting the exact cycles distinguishes the two delays;
- power-down to standby to normal, which must take the short delay;
- a wake cut short by a standby write, which shows that the count is abandoned and restarted rather than resumed.

Re-writing the same word with only bits 1:0 changed isolates the don't-care bits.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'b00,
        PWR_STANDBY = 2'b01,
        PWR_DOWN    = 2'b10
    } pwr_mode_e;

    // Field order matters: it matches bus bits 9 down to 2.
    typedef struct packed {
        logic       pd;       // 1: power-down
        logic       dac_on;   // 0 with pd=0: standby
        logic       ilv;      // interleaved inputs
        logic       ref_off;  // 1: internal reference off
        logic [3:0] trim;     // gain trim code
    } cfg_word_t;

    localparam int WORD_W = $bits(cfg_word_t);

    localparam cfg_word_t CFG_RESET = '{
        pd:      1'b0,
        dac_on:  1'b1,
        ilv:     1'b0,
        ref_off: 1'b0,
        trim:    4'b1000
    };

    function automatic pwr_mode_e decode_mode(input cfg_word_t w);
        if (w.pd)
            return PWR_DOWN;
        else if (!w.dac_on)
            return PWR_STANDBY;
        else
            return PWR_NORMAL;
    endfunction
endpackage

// File: rtl/cfg_capture.sv
// Strobe-domain capture: latches the word and flips a toggle on every write.
module cfg_capture
    import dac_cfg_pkg::*;
(
    input  logic      wr_n,
    input  logic      rst_n,
    input  cfg_word_t word_in,
    output cfg_word_t word_a,
    output logic      toggle_a
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge wr_n or negedge rst_n) begin
        if (!rst_n) begin
            word_a   <= CFG_RESET;
            toggle_a <= 1'b0;
        end else begin
            word_a   <= word_in;
            toggle_a <= ~toggle_a;
        end
    end
endmodule

// File: rtl/cfg_sync.sv
// Sample-clock side of the handshake: synchronizes the toggle, detects a
// change, and loads the stable strobe-domain word into the decode register.
module cfg_sync
    import dac_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      toggle_a,
    input  cfg_word_t word_a,
    output logic      load,
    output cfg_word_t word_q
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < CHAIN_W; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= toggle_a;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign load = chain_q[SYNC_STAGES-1] ^ chain_q[SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= CFG_RESET;
        else if (load) word_q <= word_a;
    end
endmodule

// File: rtl/pwr_fsm.sv
// Readiness state machine with a wake-up down-counter.
module pwr_fsm
    import dac_cfg_pkg::*;
#(
    parameter int STBY_CYC = 240,
    parameter int PD_CYC   = 40000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  pwr_mode_e next_mode,
    output logic      out_valid
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MAX_CYC = (PD_CYC > STBY_CYC) ? PD_CYC : STBY_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] STBY_LD = CNT_W'(STBY_CYC - 1);
    localparam logic [CNT_W-1:0] PD_LD   = CNT_W'(PD_CYC - 1);

    typedef enum logic [1:0] {ST_RUN, ST_STBY, ST_PDN, ST_WAKE} fsm_e;

    fsm_e             st_q, st_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             wake_go;
    logic [CNT_W-1:0] wake_ld;

    // Next-state logic.
    always_comb begin
        st_nx   = st_q;
        wake_go = 1'b0;
        wake_ld = STBY_LD;
        unique case (st_q)
            ST_RUN: begin
                if (load && next_mode == PWR_STANDBY)   st_nx = ST_STBY;
                else if (load && next_mode == PWR_DOWN) st_nx = ST_PDN;
            end
            ST_STBY: begin
                if (load && next_mode == PWR_NORMAL) begin
                    st_nx   = ST_WAKE;
                    wake_go = 1'b1;
                    wake_ld = STBY_LD;
                end else if (load && next_mode == PWR_DOWN) begin
                    st_nx = ST_PDN;
                end
            end
            ST_PDN: begin
                if (load && next_mode == PWR_NORMAL) begin
                    st_nx   = ST_WAKE;
                    wake_go = 1'b1;
                    wake_ld = PD_LD;
                end else if (load && next_mode == PWR_STANDBY) begin
                    st_nx = ST_STBY;
                end
            end
            ST_WAKE: begin
                if (load && next_mode == PWR_STANDBY)   st_nx = ST_STBY;
                else if (load && next_mode == PWR_DOWN) st_nx = ST_PDN;
                else if (cnt_q == '0)                   st_nx = ST_RUN;
            end
            default: st_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_nx;
    end

    // Wake-up counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wake_go)
            cnt_q <= wake_ld;
        else if (st_q == ST_WAKE && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Outputs.
    always_comb begin
        out_valid = (st_q == ST_RUN);
    end
endmodule

// File: rtl/dac_cfg_ctrl.sv
module dac_cfg_ctrl
    import dac_cfg_pkg::*;
#(
    parameter int BUS_W        = 10,
    parameter int CLK_MHZ      = 80,
    parameter int STBY_WAKE_NS = 3000,
    parameter int PD_WAKE_NS   = 500000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic [BUS_W-1:0] data_a,
    output logic [1:0]       pwr_mode,
    output logic             ilv_en,
    output logic             iref_en,
    output logic [3:0]       gain_trim,
    output logic             out_valid
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DC_W     = BUS_W - WORD_W;
    localparam int STBY_CYC = (CLK_MHZ * STBY_WAKE_NS + 999) / 1000;
    localparam int PD_CYC   = (CLK_MHZ * PD_WAKE_NS + 999) / 1000;

    cfg_word_t word_in, word_a, word_q;
    logic      toggle_a;
    logic      cfg_load;

    assign word_in = cfg_word_t'(data_a[BUS_W-1 -: WORD_W]);

    generate
        if (DC_W > 0) begin : g_dc
            logic unused_dc;
            assign unused_dc = ^data_a[DC_W-1:0];
        end
    endgenerate

    cfg_capture u_cap (
        .wr_n     (wr_n),
        .rst_n    (rst_n),
        .word_in  (word_in),
        .word_a   (word_a),
        .toggle_a (toggle_a)
    );

    cfg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .toggle_a (toggle_a),
        .word_a   (word_a),
        .load     (cfg_load),
        .word_q   (word_q)
    );

    pwr_fsm #(.STBY_CYC(STBY_CYC), .PD_CYC(PD_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .next_mode (decode_mode(word_a)),
        .out_valid (out_valid)
    );

    assign pwr_mode  = decode_mode(word_q);
    assign ilv_en    = word_q.ilv;
    assign iref_en   = ~word_q.ref_off;
    assign gain_trim = word_q.trim;
endmodule

// File: rtl/dac_cfg_ctrl_chk.sv
module dac_cfg_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load,
    input logic [1:0] pwr_mode,
    input logic       ilv_en,
    input logic       iref_en,
    input logic [3:0] gain_trim,
    input logic       out_valid
);
    timeunit 1ns;
    timeprecision 1ps;

    p_valid_needs_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pwr_mode == 2'b00));

    p_hold_without_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({pwr_mode, ilv_en, iref_en, gain_trim}));

    p_wake_starts_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'b00 && $past(pwr_mode) != 2'b00) |-> !out_valid);

    p_run_stays_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !load) |=> out_valid);

    p_legal_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != 2'b11);
endmodule

bind dac_cfg_ctrl dac_cfg_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .pwr_mode  (pwr_mode),
    .ilv_en    (ilv_en),
    .iref_en   (iref_en),
    .gain_trim (gain_trim),
    .out_valid (out_valid)
);

// File: tb/dac_cfg_ctrl_bench.sv
module dac_cfg_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_MHZ = 2;
    localparam int NS_CYC  = (CLK_MHZ * 3000 + 999) / 1000;     // 6
    localparam int NP_CYC  = (CLK_MHZ * 500000 + 999) / 1000;   // 1000

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1;
    logic [9:0] data_a = '0;
    logic [1:0] pwr_mode;
    logic       ilv_en, iref_en, out_valid;
    logic [3:0] gain_trim;

    int checks = 0;
    int failures = 0;
    int cur_mode = 0;

    always #2 clk = ~clk;

    dac_cfg_ctrl #(.CLK_MHZ(CLK_MHZ)) u_dac_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .data_a(data_a),
        .pwr_mode(pwr_mode), .ilv_en(ilv_en), .iref_en(iref_en),
        .gain_trim(gain_trim), .out_valid(out_valid)
    );

    function automatic int f_mode(input logic [9:0] w);
        if (w[9]) return 2;
        if (!w[8]) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_fields(input logic [9:0] w, input string req);
        chk(int'(pwr_mode) == f_mode(w), {req, " mode"}, int'(pwr_mode), f_mode(w));
        chk(ilv_en == w[7], {req, " ilv"}, int'(ilv_en), int'(w[7]));
        chk(iref_en == !w[6], {req, " iref"}, int'(iref_en), int'(!w[6]));
        chk(gain_trim == w[5:2], {req, " trim"}, int'(gain_trim), int'(w[5:2]));
    endtask

    task automatic strobe(input logic [9:0] w);
        data_a = w;
        #1 wr_n = 1'b0;
        #6 wr_n = 1'b1;
        #1 data_a = 10'($urandom);   // R12: bus garbage after the edge
    endtask

    task automatic do_write(input logic [9:0] w);
        int prev, nm, n, k;
        prev = cur_mode;
        nm = f_mode(w);
        strobe(w);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (n < 8 && !(int'(pwr_mode) == nm && ilv_en == w[7] &&
                              iref_en == !w[6] && gain_trim == w[5:2]));
        chk(n <= 4, "R6 update latency", n, 4);
        chk_fields(w, "R2/R3/R4");
        if (nm == 0 && prev != 0) begin
            k = 0;
            while (!out_valid && k < NP_CYC + 10) begin
                @(negedge clk);
                k++;
            end
            if (prev == 1) chk(k == NS_CYC, "R8 standby wake", k, NS_CYC);
            else           chk(k == NP_CYC, "R9 power-down wake", k, NP_CYC);
        end else if (nm == 0) begin
            chk(out_valid == 1'b1, "R10 valid kept", int'(out_valid), 1);
        end else begin
            chk(out_valid == 1'b0, "R7 valid low", int'(out_valid), 0);
        end
        repeat (4) @(negedge clk);
        chk_fields(w, "R12 bus ignored");
        cur_mode = nm;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [9:0] w;
        void'($urandom(32'h0C0FFEE));
        repeat (5) @(negedge clk);
        // R1 reset defaults
        chk(pwr_mode == 2'b00, "R1 mode", int'(pwr_mode), 0);
        chk(ilv_en == 1'b0, "R1 ilv", int'(ilv_en), 0);
        chk(iref_en == 1'b1, "R1 iref", int'(iref_en), 1);
        chk(gain_trim == 4'b1000, "R1 trim", int'(gain_trim), 8);
        chk(out_valid == 1'b1, "R1 valid", int'(out_valid), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Directed paths
        do_write(10'b01_1_1_0110_00);   // normal, trim change: R10
        do_write(10'b00_0_0_1111_11);   // standby
        do_write(10'b01_0_0_1000_00);   // R8 standby -> normal
        do_write(10'b11_1_1_0001_00);   // R3 pd with enable set
        do_write(10'b01_0_1_0011_00);   // R9 pd -> normal
        do_write(10'b10_0_0_0000_00);   // R3 pd with enable clear
        do_write(10'b00_1_0_0101_00);   // pd -> standby
        do_write(10'b01_1_0_0101_00);   // R8 short wake after pd->standby

        // R5: only bits 1:0 differ
        do_write(10'b01_0_1_1010_00);
        w = {pwr_mode == 2'b00 ? 2'b01 : 2'b01, 8'b0_1_1010_11};
        do_write(w);
        chk(out_valid == 1'b1, "R5 dont-care no effect", int'(out_valid), 1);

        // R11: abort a power-down wake with a standby write
        do_write(10'b10_0_0_0000_00);
        strobe(10'b01_0_0_1000_00);
        repeat (20) @(negedge clk);
        chk(out_valid == 1'b0, "R11 still waking", int'(out_valid), 0);
        cur_mode = 0;
        do_write(10'b00_0_0_1000_00);
        repeat (NP_CYC) @(negedge clk);
        chk(out_valid == 1'b0, "R11 abort holds low", int'(out_valid), 0);
        do_write(10'b01_0_0_1000_00);   // fresh short count (R11, R8)

        // Random
        for (int i = 0; i < 30; i++) begin
            do_write(10'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule